// File: doc/BRIEF.md
# Fused-Operation 64-bit Integer ALU

This block is the integer execution datapath of a processor back end. Each operation is named by a 7-bit code. Besides the usual add, subtract, compare, shift and logic functions, it runs several instruction pairs that the decoder merges into one operation:

- scaled-index adds (shift left by 1 to 4, then add);
- right-shift-then-add;
- an odd-bit add;
- an upper-immediate-plus-low-immediate merge;
- word adds whose sum is cut down to one bit, one byte or a halfword.

Bits [6:4] of the code pick the group: 000 shift and single-bit, 001 32-bit word, 010 add, 011 subtract and compare, 100 logic.

An operation enters as a code and two 64-bit operands with `in_vld` high. Its result appears on `out_res` with `out_vld` on the next clock. When `in_vld` is low the result register holds its value. Any code the block does not implement gives a zero result.

Top module: `fused_alu`

## Requirements
- R1: `out_vld` equals the `in_vld` of the previous clock, and `out_res` carries the result of the operation presented one clock earlier. A synchronous active-low reset clears `out_vld` and `out_res` to 0.
- R2: Shifts use src2[5:0] as the amount: 01 left, 05 logical right, 07 arithmetic right, 09 rotate left, 0B rotate right, and 00 shifts src1[31:0] (zero-extended) left.
- R3: Single-bit operations index bit src2[5:0] of src1: 02 clears it, 03 sets it, 04 inverts it, 06 returns it in bit 0.
- R4: Word arithmetic sign-extends the low 32 bits of the sum: 10 src1+src2, 11 src1[0]+src2, 12 src1-src2.
- R5: Word shifts act on src1[31:0] by src2[4:0] and sign-extend the 32-bit result: 18 left, 19 logical right, 1A arithmetic right, 1C rotate left, 1D rotate right.
- R6: Truncated word adds of src1+src2: 14 gives bit 0 only, 15 the zero-extended low byte, 16 the zero-extended low halfword, 17 the sign-extended low halfword.
- R7: Scaled adds compute (src1 << N) + src2 with zero fill. Codes 29, 2B, 2D, 2F give N = 1, 2, 3, 4. Codes 28, 2A, 2C give N = 1, 2, 3 with src1 first replaced by src1[31:0] zero-extended.
- R8: Codes 24, 25, 26, 27 compute (src1 logically shifted right by 29, 30, 31, 32) + src2.
- R9: 21 is src1+src2, 22 is src1[0]+src2, and 20 is src1[31:0] zero-extended plus src2.
- R10: Code 23 returns src2[11:0] sign-extended plus src2 with bits [11:0] cleared. Code 13 returns the low 32 bits of that sum, sign-extended.
- R11: 30 is src1-src2. 31 and 32 return 1 in bit 0 when src1 < src2 (unsigned, signed), else 0. 34/35 give the unsigned max/min and 36/37 the signed max/min.
- R12: Logic codes:
  - 40 and, 41 and-not, 42 or, 43 or-not, 44 xor, 45 xnor;
  - 46 sets each byte of src1 to FF if it is nonzero, else 00;
  - 48 sign-extends src1[7:0] and 4A sign-extends src1[15:0];
  - 49 gives {src2[7:0], src1[7:0]} zero-extended;
  - 4B gives {src2[15:0], src1[15:0]} sign-extended.
- R13: Every code not listed in R2 to R12, including all codes with bits [6:4] above 100, produces a zero result.
- R14: While `in_vld` is low, `out_res` keeps its value whatever the code and operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operation present this cycle |
| in_op | input | 7 | Operation code |
| in_a | input | 64 | First operand (src1) |
| in_b | input | 64 | Second operand (src2) |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_res | output | 64 | Registered result |

## Verification
The only state is the result register and its valid flag, so a wrong decode or a wrong operand path shows up as a wrong `out_res` exactly one clock after the faulty operation. Nothing carries an error forward to later results.

Each of the 128 codes is run against corner operands (zero, all ones, sign bit alone, one, a bit-31 pattern) and against random values. Scaled adds, rotates at amount zero and signed-versus-unsigned compares therefore each meet a case that tells them apart from their neighbours.

A lost hold or a late valid appears as a changed register while idle, or as a valid pulse that does not line up with the issue cycle.

// File: rtl/fused_alu_pkg.sv
package fused_alu_pkg;
    localparam int XLEN   = 64;
    localparam int HALF   = XLEN / 2;
    localparam int OPW    = 7;
    localparam int SHW    = $clog2(XLEN);
    localparam int WSHW   = $clog2(HALF);
    localparam int BYTE_W = 8;
    localparam int HW_W   = 16;
    localparam int IMM_LO = 12;

    typedef logic [XLEN-1:0] xword_t;
    typedef logic [OPW-1:0]  opcode_t;

    localparam logic [2:0] GRP_SHIFT = 3'b000;
    localparam logic [2:0] GRP_WORD  = 3'b001;
    localparam logic [2:0] GRP_ADD   = 3'b010;
    localparam logic [2:0] GRP_CMP   = 3'b011;
    localparam logic [2:0] GRP_LOGIC = 3'b100;

    localparam opcode_t OP_SLLUW = 7'h00, OP_SLL = 7'h01, OP_BITCLR = 7'h02, OP_BITSET = 7'h03;
    localparam opcode_t OP_BITFLIP = 7'h04, OP_SRL = 7'h05, OP_BITGET = 7'h06, OP_SRA = 7'h07;
    localparam opcode_t OP_ROTL = 7'h09, OP_ROTR = 7'h0B;
    localparam opcode_t OP_ADDW = 7'h10, OP_ODDADDW = 7'h11, OP_SUBW = 7'h12, OP_LUIADDW = 7'h13;
    localparam opcode_t OP_ADDW_B1 = 7'h14, OP_ADDW_B8 = 7'h15, OP_ADDW_ZH = 7'h16, OP_ADDW_SH = 7'h17;
    localparam opcode_t OP_SLLW = 7'h18, OP_SRLW = 7'h19, OP_SRAW = 7'h1A, OP_ROTLW = 7'h1C, OP_ROTRW = 7'h1D;
    localparam opcode_t OP_ADDUW = 7'h20, OP_ADD = 7'h21, OP_ODDADD = 7'h22, OP_LUIADD = 7'h23;
    localparam opcode_t OP_SR29ADD = 7'h24, OP_SR30ADD = 7'h25, OP_SR31ADD = 7'h26, OP_SR32ADD = 7'h27;
    localparam opcode_t OP_SH1ADDUW = 7'h28, OP_SH1ADD = 7'h29, OP_SH2ADDUW = 7'h2A, OP_SH2ADD = 7'h2B;
    localparam opcode_t OP_SH3ADDUW = 7'h2C, OP_SH3ADD = 7'h2D, OP_SH4ADD = 7'h2F;
    localparam opcode_t OP_SUB = 7'h30, OP_SLTU = 7'h31, OP_SLT = 7'h32;
    localparam opcode_t OP_MAXU = 7'h34, OP_MINU = 7'h35, OP_MAX = 7'h36, OP_MIN = 7'h37;
    localparam opcode_t OP_AND = 7'h40, OP_ANDN = 7'h41, OP_OR = 7'h42, OP_ORN = 7'h43;
    localparam opcode_t OP_XOR = 7'h44, OP_XNOR = 7'h45, OP_ORCB = 7'h46;
    localparam opcode_t OP_SEXTB = 7'h48, OP_PACKH = 7'h49, OP_SEXTH = 7'h4A, OP_PACKW = 7'h4B;

    // How the shared adder's output is turned into a result
    typedef enum logic [3:0] {
        FMT_NONE, FMT_FULL, FMT_WORD, FMT_BIT, FMT_BYTE, FMT_ZHALF, FMT_SHALF,
        FMT_LTU, FMT_LT, FMT_MAXU, FMT_MINU, FMT_MAX, FMT_MIN
    } fmt_e;

    function automatic xword_t widen_z(input logic [HALF-1:0] v);
        return {{HALF{1'b0}}, v};
    endfunction

    function automatic xword_t widen_s(input logic [HALF-1:0] v);
        return {{HALF{v[HALF-1]}}, v};
    endfunction
endpackage

// File: rtl/fused_alu_shift.sv
// Shift, rotate and single-bit unit: covers the shift group and the word
// shifts/rotates of the word group. Assumes a purely combinational context;
// outputs zero and a low hit flag for codes it does not own.
module fused_alu_shift
    import fused_alu_pkg::*;
(
    input  opcode_t op,
    input  xword_t  a,
    input  xword_t  b,
    output xword_t  res,
    output logic    hit
);
    logic [SHW-1:0]    amt;
    logic [WSHW-1:0]   wamt;
    logic [HALF-1:0]   lo;
    logic [2*XLEN-1:0] dbl;
    logic [XLEN-1:0]   wdbl;
    logic [HALF-1:0]   wtmp;
    xword_t            onehot;

    assign amt    = b[SHW-1:0];
    assign wamt   = b[WSHW-1:0];
    assign lo     = a[HALF-1:0];
    assign onehot = xword_t'(1) << amt;

    // Select the shift/bit result for the given code
    always_comb begin
        res  = '0;
        hit  = 1'b1;
        dbl  = '0;
        wdbl = '0;
        wtmp = '0;
        case (op)
            OP_SLLUW:   res = widen_z(lo) << amt;
            OP_SLL:     res = a << amt;
            OP_BITCLR:  res = a & ~onehot;
            OP_BITSET:  res = a | onehot;
            OP_BITFLIP: res = a ^ onehot;
            OP_SRL:     res = a >> amt;
            OP_BITGET:  res = {{(XLEN-1){1'b0}}, a[amt]};
            OP_SRA:     res = xword_t'($signed(a) >>> amt);
            OP_ROTL: begin
                dbl = {a, a} << amt;
                res = dbl[2*XLEN-1:XLEN];
            end
            OP_ROTR: begin
                dbl = {a, a} >> amt;
                res = dbl[XLEN-1:0];
            end
            OP_SLLW: begin
                wtmp = lo << wamt;
                res  = widen_s(wtmp);
            end
            OP_SRLW: begin
                wtmp = lo >> wamt;
                res  = widen_s(wtmp);
            end
            OP_SRAW: begin
                wtmp = HALF'($signed(lo) >>> wamt);
                res  = widen_s(wtmp);
            end
            OP_ROTLW: begin
                wdbl = {lo, lo} << wamt;
                wtmp = wdbl[XLEN-1:HALF];
                res  = widen_s(wtmp);
            end
            OP_ROTRW: begin
                wdbl = {lo, lo} >> wamt;
                wtmp = wdbl[HALF-1:0];
                res  = widen_s(wtmp);
            end
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fused_alu_adder.sv
// Adder-based unit: word arithmetic, the add group (including the fused
// shift-add, right-shift-add, odd-add and upper-plus-low immediate merge)
// and subtract/compare. One shared 65-bit adder; an operand-select stage in
// front and a format stage behind. Outputs zero for codes it does not own.
module fused_alu_adder
    import fused_alu_pkg::*;
(
    input  opcode_t op,
    input  xword_t  a,
    input  xword_t  b,
    output xword_t  res,
    output logic    hit
);
    xword_t         opa, opb, lui_lo, lui_hi, sh_base;
    logic           sub;
    fmt_e           fmt;
    logic [2:0]     sh_n;
    logic [XLEN:0]  sum;
    xword_t         diff;
    logic           ltu, lts;

    assign lui_lo  = {{(XLEN-IMM_LO){b[IMM_LO-1]}}, b[IMM_LO-1:0]};
    assign lui_hi  = {b[XLEN-1:IMM_LO], {IMM_LO{1'b0}}};
    assign sh_base = op[0] ? a : widen_z(a[HALF-1:0]);
    assign sh_n    = {1'b0, op[2:1]} + 3'd1;

    // Operand selection and result format per code
    always_comb begin
        opa = a;
        opb = b;
        sub = 1'b0;
        fmt = FMT_FULL;
        hit = 1'b1;
        case (op)
            OP_ADDW:     fmt = FMT_WORD;
            OP_ODDADDW: begin opa = {{(XLEN-1){1'b0}}, a[0]}; fmt = FMT_WORD; end
            OP_SUBW:    begin sub = 1'b1; fmt = FMT_WORD; end
            OP_LUIADDW: begin opa = lui_lo; opb = lui_hi; fmt = FMT_WORD; end
            OP_ADDW_B1:  fmt = FMT_BIT;
            OP_ADDW_B8:  fmt = FMT_BYTE;
            OP_ADDW_ZH:  fmt = FMT_ZHALF;
            OP_ADDW_SH:  fmt = FMT_SHALF;
            OP_ADDUW:    opa = widen_z(a[HALF-1:0]);
            OP_ADD:      opa = a;
            OP_ODDADD:   opa = {{(XLEN-1){1'b0}}, a[0]};
            OP_LUIADD:  begin opa = lui_lo; opb = lui_hi; end
            OP_SR29ADD:  opa = a >> 29;
            OP_SR30ADD:  opa = a >> 30;
            OP_SR31ADD:  opa = a >> 31;
            OP_SR32ADD:  opa = a >> 32;
            OP_SH1ADDUW, OP_SH1ADD, OP_SH2ADDUW, OP_SH2ADD,
            OP_SH3ADDUW, OP_SH3ADD, OP_SH4ADD:
                         opa = sh_base << sh_n;
            OP_SUB:      sub = 1'b1;
            OP_SLTU:    begin sub = 1'b1; fmt = FMT_LTU;  end
            OP_SLT:     begin sub = 1'b1; fmt = FMT_LT;   end
            OP_MAXU:    begin sub = 1'b1; fmt = FMT_MAXU; end
            OP_MINU:    begin sub = 1'b1; fmt = FMT_MINU; end
            OP_MAX:     begin sub = 1'b1; fmt = FMT_MAX;  end
            OP_MIN:     begin sub = 1'b1; fmt = FMT_MIN;  end
            default:    begin hit = 1'b0; fmt = FMT_NONE; end
        endcase
    end

    assign sum  = {1'b0, opa} + {1'b0, sub ? ~opb : opb} + {{XLEN{1'b0}}, sub};
    assign diff = sum[XLEN-1:0];
    assign ltu  = ~sum[XLEN];
    assign lts  = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : diff[XLEN-1];

    // Shape the adder output into the final result
    always_comb begin
        case (fmt)
            FMT_FULL:  res = diff;
            FMT_WORD:  res = widen_s(diff[HALF-1:0]);
            FMT_BIT:   res = {{(XLEN-1){1'b0}}, diff[0]};
            FMT_BYTE:  res = {{(XLEN-BYTE_W){1'b0}}, diff[BYTE_W-1:0]};
            FMT_ZHALF: res = {{(XLEN-HW_W){1'b0}}, diff[HW_W-1:0]};
            FMT_SHALF: res = {{(XLEN-HW_W){diff[HW_W-1]}}, diff[HW_W-1:0]};
            FMT_LTU:   res = {{(XLEN-1){1'b0}}, ltu};
            FMT_LT:    res = {{(XLEN-1){1'b0}}, lts};
            FMT_MAXU:  res = ltu ? b : a;
            FMT_MINU:  res = ltu ? a : b;
            FMT_MAX:   res = lts ? b : a;
            FMT_MIN:   res = lts ? a : b;
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/fused_alu_logic.sv
// Bitwise and packing unit for the logic group. Combinational; returns zero
// for codes it does not own.
module fused_alu_logic
    import fused_alu_pkg::*;
(
    input  opcode_t op,
    input  xword_t  a,
    input  xword_t  b,
    output xword_t  res
);
    xword_t orcb;

    // Byte-wise OR-combine: each byte becomes all ones if any bit is set
    for (genvar g = 0; g < XLEN / BYTE_W; g++) begin : g_byte
        assign orcb[g*BYTE_W +: BYTE_W] = {BYTE_W{|a[g*BYTE_W +: BYTE_W]}};
    end

    // Select the logic result
    always_comb begin
        case (op)
            OP_AND:   res = a & b;
            OP_ANDN:  res = a & ~b;
            OP_OR:    res = a | b;
            OP_ORN:   res = a | ~b;
            OP_XOR:   res = a ^ b;
            OP_XNOR:  res = ~(a ^ b);
            OP_ORCB:  res = orcb;
            OP_SEXTB: res = {{(XLEN-BYTE_W){a[BYTE_W-1]}}, a[BYTE_W-1:0]};
            OP_PACKH: res = {{(XLEN-2*BYTE_W){1'b0}}, b[BYTE_W-1:0], a[BYTE_W-1:0]};
            OP_SEXTH: res = {{(XLEN-HW_W){a[HW_W-1]}}, a[HW_W-1:0]};
            OP_PACKW: res = widen_s({b[HW_W-1:0], a[HW_W-1:0]});
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/fused_alu.sv
// Top of the fused-operation ALU. Decodes the group from op[6:4], picks the
// owning unit's result and registers it with a valid flag (one-cycle
// latency). Assumes synchronous active-low reset; result holds when idle.
module fused_alu
    import fused_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [OPW-1:0]  in_op,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    output logic            out_vld,
    output logic [XLEN-1:0] out_res
);
    xword_t sh_res, add_res, lg_res, nxt;
    logic   sh_hit, add_hit;

    fused_alu_shift u_shift (.op(in_op), .a(in_a), .b(in_b), .res(sh_res),  .hit(sh_hit));
    fused_alu_adder u_adder (.op(in_op), .a(in_a), .b(in_b), .res(add_res), .hit(add_hit));
    fused_alu_logic u_logic (.op(in_op), .a(in_a), .b(in_b), .res(lg_res));

    // Group steering of the unit results
    always_comb begin
        case (in_op[OPW-1:OPW-3])
            GRP_SHIFT:        nxt = sh_hit ? sh_res : '0;
            GRP_WORD:         nxt = sh_hit ? sh_res : (add_hit ? add_res : '0);
            GRP_ADD, GRP_CMP: nxt = add_hit ? add_res : '0;
            GRP_LOGIC:        nxt = lg_res;
            default:          nxt = '0;
        endcase
    end

    // Result register and valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_res <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_res <= nxt;
        end
    end
endmodule

// File: rtl/fused_alu_checker.sv
// Temporal properties of the fused ALU ports; bound to every instance.
module fused_alu_checker
    import fused_alu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_vld,
    input logic [OPW-1:0]  in_op,
    input logic [XLEN-1:0] in_a,
    input logic [XLEN-1:0] in_b,
    input logic            out_vld,
    input logic [XLEN-1:0] out_res
);
    a_r1_vld_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    a_r1_vld_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    a_r14_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_res));
    a_r13_unused_group: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op[OPW-1:OPW-3] > GRP_LOGIC) |=> out_res == '0);
    a_r11_flag_only: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (in_op == OP_SLT || in_op == OP_SLTU)) |=> out_res[XLEN-1:1] == '0);
    a_r11_min_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == OP_MINU) |=> (out_res == $past(in_a) || out_res == $past(in_b)));
    a_r6_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == OP_ADDW_B1) |=> out_res[XLEN-1:1] == '0);
    a_r4_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == OP_ADDW) |=> out_res[XLEN-1:HALF] == {HALF{out_res[HALF-1]}});
endmodule

bind fused_alu fused_alu_checker u_chk (.*);

// File: tb/fused_alu_test.sv
`timescale 1ns/1ps
module fused_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [6:0]  in_op = '0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_vld;
    logic [63:0] out_res;

    int total = 0;
    int bad = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [6:0]  op_q[$];

    always #2.5 clk = ~clk;

    fused_alu uut (.*);

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] lui_ref(input logic [63:0] b);
        return {{52{b[11]}}, b[11:0]} + {b[63:12], 12'b0};
    endfunction

    // Behavioural reference built from the requirement text
    function automatic logic [63:0] ref_model(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] s;
        logic [31:0] w;
        int sa, sw;
        sa = int'(b[5:0]);
        sw = int'(b[4:0]);
        s = a + b;
        case (op)
            7'h00: return {32'b0, a[31:0]} << sa;
            7'h01: return a << sa;
            7'h02: return a & ~(64'd1 << sa);
            7'h03: return a | (64'd1 << sa);
            7'h04: return a ^ (64'd1 << sa);
            7'h05: return a >> sa;
            7'h06: return (a >> sa) & 64'd1;
            7'h07: return $signed(a) >>> sa;
            7'h09: return (a << sa) | (a >> (64 - sa));
            7'h0B: return (a >> sa) | (a << (64 - sa));
            7'h10: return sx32(s[31:0]);
            7'h11: begin s = {63'b0, a[0]} + b; return sx32(s[31:0]); end
            7'h12: begin s = a - b; return sx32(s[31:0]); end
            7'h13: begin s = lui_ref(b); return sx32(s[31:0]); end
            7'h14: return s & 64'h1;
            7'h15: return s & 64'hFF;
            7'h16: return s & 64'hFFFF;
            7'h17: return {{48{s[15]}}, s[15:0]};
            7'h18: begin w = a[31:0] << sw; return sx32(w); end
            7'h19: begin w = a[31:0] >> sw; return sx32(w); end
            7'h1A: begin w = $signed(a[31:0]) >>> sw; return sx32(w); end
            7'h1C: begin w = (a[31:0] << sw) | (a[31:0] >> (32 - sw)); return sx32(w); end
            7'h1D: begin w = (a[31:0] >> sw) | (a[31:0] << (32 - sw)); return sx32(w); end
            7'h20: return {32'b0, a[31:0]} + b;
            7'h21: return s;
            7'h22: return {63'b0, a[0]} + b;
            7'h23: return lui_ref(b);
            7'h24: return (a >> 29) + b;
            7'h25: return (a >> 30) + b;
            7'h26: return (a >> 31) + b;
            7'h27: return (a >> 32) + b;
            7'h28: return ({32'b0, a[31:0]} << 1) + b;
            7'h29: return (a << 1) + b;
            7'h2A: return ({32'b0, a[31:0]} << 2) + b;
            7'h2B: return (a << 2) + b;
            7'h2C: return ({32'b0, a[31:0]} << 3) + b;
            7'h2D: return (a << 3) + b;
            7'h2F: return (a << 4) + b;
            7'h30: return a - b;
            7'h31: return (a < b) ? 64'd1 : 64'd0;
            7'h32: return ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
            7'h34: return (a > b) ? a : b;
            7'h35: return (a < b) ? a : b;
            7'h36: return ($signed(a) > $signed(b)) ? a : b;
            7'h37: return ($signed(a) < $signed(b)) ? a : b;
            7'h40: return a & b;
            7'h41: return a & ~b;
            7'h42: return a | b;
            7'h43: return a | ~b;
            7'h44: return a ^ b;
            7'h45: return ~(a ^ b);
            7'h46: begin
                s = '0;
                for (int k = 0; k < 8; k++)
                    if (a[k*8 +: 8] != 8'h00) s[k*8 +: 8] = 8'hFF;
                return s;
            end
            7'h48: return {{56{a[7]}}, a[7:0]};
            7'h49: return {48'b0, b[7:0], a[7:0]};
            7'h4A: return {{48{a[15]}}, a[15:0]};
            7'h4B: return sx32({b[15:0], a[15:0]});
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [6:0] op);
        case (op)
            7'h00, 7'h01, 7'h05, 7'h07, 7'h09, 7'h0B: return "R2";
            7'h02, 7'h03, 7'h04, 7'h06: return "R3";
            7'h10, 7'h11, 7'h12: return "R4";
            7'h18, 7'h19, 7'h1A, 7'h1C, 7'h1D: return "R5";
            7'h14, 7'h15, 7'h16, 7'h17: return "R6";
            7'h28, 7'h29, 7'h2A, 7'h2B, 7'h2C, 7'h2D, 7'h2F: return "R7";
            7'h24, 7'h25, 7'h26, 7'h27: return "R8";
            7'h20, 7'h21, 7'h22: return "R9";
            7'h13, 7'h23: return "R10";
            7'h30, 7'h31, 7'h32, 7'h34, 7'h35, 7'h36, 7'h37: return "R11";
            7'h40, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45, 7'h46,
            7'h48, 7'h49, 7'h4A, 7'h4B: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: present one operation and queue its expected result
    task automatic drive(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_vld = 1'b1;
        in_op  = op;
        in_a   = a;
        in_b   = b;
        exp_q.push_back(ref_model(op, a, b));
        tag_q.push_back(tag_of(op));
        op_q.push_back(op);
    endtask

    // Monitor: compare each valid result against the scoreboard (R1 ordering)
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (exp_q.size() == 0) begin
                check("R1", 64'd1, 64'd0, "valid with nothing issued");
            end else begin
                logic [63:0] e;
                string t;
                logic [6:0] o;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                o = op_q.pop_front();
                check(t, out_res, e, $sformatf("op %h", o));
            end
        end
    end

    // Watchdog
    initial begin
        #(100000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] corner [6];
        logic [63:0] held;
        corner[0] = 64'd0;
        corner[1] = '1;
        corner[2] = 64'h8000_0000_0000_0000;
        corner[3] = 64'd1;
        corner[4] = 64'h0000_0000_8000_7FFF;
        corner[5] = 64'h0123_4567_89AB_CDEF;

        repeat (3) @(negedge clk);
        check("R1", {63'b0, out_vld}, 64'd0, "reset valid");
        check("R1", out_res, 64'd0, "reset result");
        rst_n = 1'b1;

        for (int op = 0; op < 128; op++) begin
            for (int i = 0; i < 6; i++)
                drive(7'(op), corner[i], corner[(i * 5 + 1) % 6]);
            drive(7'(op), corner[2], corner[2]);
            drive(7'(op), corner[4], 64'd40);
            for (int r = 0; r < 4; r++)
                drive(7'(op), {$urandom, $urandom}, {$urandom, $urandom});
        end

        @(negedge clk);
        in_vld = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 64'(exp_q.size()), 64'd0, "all results delivered");

        // R14: idle cycles with changing inputs must not disturb the result
        held = out_res;
        for (int k = 0; k < 3; k++) begin
            in_op = 7'h21;
            in_a  = {$urandom, $urandom};
            in_b  = {$urandom, $urandom};
            @(negedge clk);
            check("R14", out_res, held, "result held while idle");
            check("R14", {63'b0, out_vld}, 64'd0, "valid low while idle");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule